// File: doc/BRIEF.md
# Event record writer with deferred trigger fill

This block lays out one complete event record in a RAM with 64-bit rows, starting at a base row chosen at start. Each row holds four 16-bit lanes, and lane 0 sits in bits 15:0. A start pulse latches the base row and the region-of-interest length (ROI). The block then writes a header, a run of channel groups and a closing footer. Each group carries one lane for each of four digitizer chips.

While the writer waits for ADC samples of a group, each incoming sample row is stored as it arrives. The trigger identification comes in much later over a slow serial path, so the two header rows that carry it are skipped at first. They are written only after the last sample row and after the trigger identification has been captured. The footer follows them. A done pulse marks the footer write.

Top module: `event_record_writer`

## Requirements
- R1: After reset `wr_en_o` and `done_o` are low. No row is written while the writer is idle. A start pulse is accepted only while idle, and a start during an event has no effect on the rows written.
- R2: The first write of an event goes to row `base`. Its lanes 0..3 hold 0xFB01, the length, the version and 0. The length is 24 + 4·G·(ROI+3), where G is the group count (10 by default), so it is 0x1030 for ROI 100.
- R3: The header continues with rows base+3, base+4, base+5 and base+6, in that order. Row base+3 holds the board word in lane 0 and zeros elsewhere. The board word has bits 15:12 = 0, bits 11:8 = crate ID, bits 7:4 = 8 and bits 3:0 = board ID. Row base+4 holds the four temperatures (temperature c in lane c). Row base+5 holds DAC words 0..3 and row base+6 holds DAC words 4..7. Rows base+1 and base+2 are not written at this point.
- R4: Group g (0..G-1) starts at row base+7+g·(ROI+3). Its first row holds (c<<4)|g in lane c. Its second row holds the stop position of chip c in lane c. Its third row holds the ROI in every lane.
- R5: During a group's sample window, each cycle with `samp_valid_i` high writes `samp_data_i` on the next cycle. The ROI sample rows follow the ROI row at consecutive addresses. `samp_valid_i` outside the sample windows has no effect. With ROI 0 a group has no sample rows.
- R6: The first `trig_valid_i` pulse after start is captured with its event counter, external ID and internal ID. Later pulses in the same event are ignored.
- R7: After the last sample row of the last group, row base+1 is written with lanes {counter[15:0], counter[31:16], external ID, 0}. Then row base+2 is written with the internal ID in lane 2. Until a trigger has been captured, no write occurs.
- R8: The footer is the last write. It goes to row base+7+G·(ROI+3) with lanes {0x4242, 0x04FE, 0, 0}. `done_o` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of an event record |
| base_i | input | ADDR_W | First row of the record |
| roi_i | input | ROI_W | Sample rows per group |
| version_i | input | 16 | Format version word |
| crate_id_i | input | 4 | Crate number |
| board_id_i | input | 4 | Board number |
| temp_i | input | 64 | Four temperatures, lane c = chip c |
| dac_i | input | 128 | Eight DAC settings, word k at bits 16k+15:16k |
| stop_pos_i | input | 64 | Stop position per chip |
| samp_valid_i | input | 1 | Sample row strobe |
| samp_data_i | input | 64 | Four ADC sample lanes |
| trig_valid_i | input | 1 | Trigger identification present |
| trig_evt_i | input | 32 | Event counter |
| trig_ext_i | input | 16 | External trigger ID |
| trig_int_i | input | 16 | Internal trigger ID |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | ADDR_W | RAM row address |
| wr_data_o | output | 64 | RAM row data |
| done_o | output | 1 | Footer written |

## Verification
The record is exercised with four event shapes:
- A contiguous sample stream with the trigger arriving during the header. This separates correct deferral of the trigger rows from writing them early.
- ROI 0 with a late trigger. This shows that empty groups still produce their three leading rows and reach the waiting state.
- A sample stream with idle gaps and a late trigger. This shows that rows follow the strobe, not the cycle count, and that the writer stays silent while it waits.
- ROI 100. This checks the length word and the group and footer placement at a realistic size.

Stray strobes, a second trigger pulse and a start issued during an event are mixed in. Any of them taking effect would show up as a mismatched or unexpected row.

// File: rtl/evw_pkg.sv
package evw_pkg;

    localparam int LANES         = 4;
    localparam int LANE_W        = 16;
    localparam int ROW_W         = LANES * LANE_W;
    localparam int HDR_ROWS      = 7;
    localparam int GRP_META_ROWS = 3;
    localparam int HDR_WORDS16   = 22;
    localparam int FOOT_WORDS16  = 2;

    localparam logic [LANE_W-1:0] START_FLAG = 16'hFB01;
    localparam logic [LANE_W-1:0] END_FLAG   = 16'h04FE;
    localparam logic [LANE_W-1:0] CRC_FILL   = 16'h4242;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0][LANE_W-1:0] row_t;

    typedef enum logic [3:0] {
        ROW_NONE, ROW_HEAD, ROW_TRG_EXT, ROW_TRG_INT, ROW_BOARD, ROW_TEMP,
        ROW_DACLO, ROW_DACHI, ROW_GID, ROW_STOP, ROW_ROI, ROW_SAMP, ROW_FOOT
    } row_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_GID, ST_STOP, ST_ROI, ST_SAMP,
        ST_TWAIT, ST_TEXT, ST_TINT, ST_FOOT
    } wr_state_t;

    typedef struct packed {
        logic [31:0] evt;
        lane_t       ext_id;
        lane_t       int_id;
    } trig_info_t;

    // number of nonzero 16-bit words a narrow reader emits for one record
    function automatic lane_t packet_len(input int unsigned roi, input int unsigned ngroups);
        int unsigned words;
        words = HDR_WORDS16 + FOOT_WORDS16 + ngroups * LANES * (roi + GRP_META_ROWS);
        return lane_t'(words);
    endfunction

    function automatic row_t make_row(input lane_t l0, input lane_t l1,
                                      input lane_t l2, input lane_t l3);
        row_t r;
        r[0] = l0;
        r[1] = l1;
        r[2] = l2;
        r[3] = l3;
        return r;
    endfunction

endpackage

// File: rtl/evw_trig_latch.sv
module evw_trig_latch
    import evw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       en_i,
    input  logic       valid_i,
    input  trig_info_t info_i,
    output logic       have_o,
    output trig_info_t info_o
);

    logic       have_q;
    trig_info_t info_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            info_q <= '0;
        end else if (clr_i) begin
            have_q <= 1'b0;
        end else if (en_i && valid_i && !have_q) begin
            have_q <= 1'b1;
            info_q <= info_i;
        end
    end

    assign have_o = have_q;
    assign info_o = info_q;

endmodule

// File: rtl/evw_seq.sv
module evw_seq
    import evw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROI_W    = 10,
    parameter int N_GROUPS = 10,
    localparam int GRP_W   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ROI_W-1:0]  roi_i,
    input  logic              samp_valid_i,
    input  logic              trig_have_i,
    output wr_state_t         state_o,
    output row_kind_t         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [GRP_W-1:0]  grp_o,
    output logic [ROI_W-1:0]  roi_o,
    output logic              we_o,
    output logic              accept_o
);

    wr_state_t         state_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ROI_W-1:0]  roi_q;
    logic [ROI_W-1:0]  cnt_q;
    logic [GRP_W-1:0]  grp_q;
    logic [2:0]        hidx_q;

    logic last_grp;
    logic last_samp;

    assign last_grp  = (grp_q == GRP_W'(N_GROUPS - 1));
    assign last_samp = (cnt_q == roi_q - ROI_W'(1));
    assign accept_o  = (state_q == ST_IDLE) && start_i;

    always_comb begin
        kind_o = ROW_NONE;
        addr_o = ptr_q;
        we_o   = 1'b0;
        case (state_q)
            ST_HDR: begin
                we_o   = 1'b1;
                addr_o = base_q + ADDR_W'(hidx_q);
                case (hidx_q)
                    3'd0:    kind_o = ROW_HEAD;
                    3'd3:    kind_o = ROW_BOARD;
                    3'd4:    kind_o = ROW_TEMP;
                    3'd5:    kind_o = ROW_DACLO;
                    default: kind_o = ROW_DACHI;
                endcase
            end
            ST_GID:  begin we_o = 1'b1; kind_o = ROW_GID;  end
            ST_STOP: begin we_o = 1'b1; kind_o = ROW_STOP; end
            ST_ROI:  begin we_o = 1'b1; kind_o = ROW_ROI;  end
            ST_SAMP: begin we_o = samp_valid_i; kind_o = ROW_SAMP; end
            ST_TEXT: begin
                we_o   = 1'b1;
                kind_o = ROW_TRG_EXT;
                addr_o = base_q + ADDR_W'(1);
            end
            ST_TINT: begin
                we_o   = 1'b1;
                kind_o = ROW_TRG_INT;
                addr_o = base_q + ADDR_W'(2);
            end
            ST_FOOT: begin we_o = 1'b1; kind_o = ROW_FOOT; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
            roi_q   <= '0;
            cnt_q   <= '0;
            grp_q   <= '0;
            hidx_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    base_q  <= base_i;
                    roi_q   <= roi_i;
                    ptr_q   <= base_i + ADDR_W'(HDR_ROWS);
                    hidx_q  <= '0;
                    grp_q   <= '0;
                    cnt_q   <= '0;
                    state_q <= ST_HDR;
                end
                ST_HDR: begin
                    hidx_q <= (hidx_q == 3'd0) ? 3'd3 : hidx_q + 3'd1;
                    if (hidx_q == 3'd6) state_q <= ST_GID;
                end
                ST_GID: begin
                    ptr_q   <= ptr_q + ADDR_W'(1);
                    state_q <= ST_STOP;
                end
                ST_STOP: begin
                    ptr_q   <= ptr_q + ADDR_W'(1);
                    state_q <= ST_ROI;
                end
                ST_ROI: begin
                    ptr_q <= ptr_q + ADDR_W'(1);
                    cnt_q <= '0;
                    if (roi_q != '0) begin
                        state_q <= ST_SAMP;
                    end else if (last_grp) begin
                        state_q <= ST_TWAIT;
                    end else begin
                        grp_q   <= grp_q + GRP_W'(1);
                        state_q <= ST_GID;
                    end
                end
                ST_SAMP: if (samp_valid_i) begin
                    ptr_q <= ptr_q + ADDR_W'(1);
                    cnt_q <= cnt_q + ROI_W'(1);
                    if (last_samp) begin
                        if (last_grp) begin
                            state_q <= ST_TWAIT;
                        end else begin
                            grp_q   <= grp_q + GRP_W'(1);
                            state_q <= ST_GID;
                        end
                    end
                end
                ST_TWAIT: if (trig_have_i) state_q <= ST_TEXT;
                ST_TEXT:  state_q <= ST_TINT;
                ST_TINT:  state_q <= ST_FOOT;
                ST_FOOT:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign grp_o   = grp_q;
    assign roi_o   = roi_q;

endmodule

// File: rtl/evw_fmt.sv
module evw_fmt
    import evw_pkg::*;
#(
    parameter int ROI_W  = 10,
    parameter int GRP_W  = 4
) (
    input  row_kind_t        kind_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [ROI_W-1:0] roi_i,
    input  lane_t            len_i,
    input  lane_t            version_i,
    input  logic [3:0]       crate_i,
    input  logic [3:0]       board_i,
    input  row_t             temp_i,
    input  row_t             dac_lo_i,
    input  row_t             dac_hi_i,
    input  row_t             stop_i,
    input  row_t             samp_i,
    input  trig_info_t       trig_i,
    output row_t             row_o
);

    row_t gid_row;
    row_t roi_row;

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        assign gid_row[c] = {8'h00, 4'(c), 4'(grp_i)};
        assign roi_row[c] = LANE_W'(roi_i);
    end

    always_comb begin
        case (kind_i)
            ROW_HEAD:    row_o = make_row(START_FLAG, len_i, version_i, '0);
            ROW_TRG_EXT: row_o = make_row(trig_i.evt[15:0], trig_i.evt[31:16], trig_i.ext_id, '0);
            ROW_TRG_INT: row_o = make_row(trig_i.evt[15:0], trig_i.evt[31:16], trig_i.int_id, '0);
            ROW_BOARD:   row_o = make_row({4'h0, crate_i, 4'h8, board_i}, '0, '0, '0);
            ROW_TEMP:    row_o = temp_i;
            ROW_DACLO:   row_o = dac_lo_i;
            ROW_DACHI:   row_o = dac_hi_i;
            ROW_GID:     row_o = gid_row;
            ROW_STOP:    row_o = stop_i;
            ROW_ROI:     row_o = roi_row;
            ROW_SAMP:    row_o = samp_i;
            ROW_FOOT:    row_o = make_row(CRC_FILL, END_FLAG, '0, '0);
            default:     row_o = '0;
        endcase
    end

endmodule

// File: rtl/event_record_writer.sv
module event_record_writer
    import evw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROI_W    = 10,
    parameter int N_GROUPS = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [ROI_W-1:0]      roi_i,
    input  logic [15:0]           version_i,
    input  logic [3:0]            crate_id_i,
    input  logic [3:0]            board_id_i,
    input  logic [63:0]           temp_i,
    input  logic [127:0]          dac_i,
    input  logic [63:0]           stop_pos_i,
    input  logic                  samp_valid_i,
    input  logic [63:0]           samp_data_i,
    input  logic                  trig_valid_i,
    input  logic [31:0]           trig_evt_i,
    input  logic [15:0]           trig_ext_i,
    input  logic [15:0]           trig_int_i,
    output logic                  wr_en_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [63:0]           wr_data_o,
    output logic                  done_o
);

    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

    wr_state_t         seq_state;
    row_kind_t         kind;
    logic [ADDR_W-1:0] row_addr;
    logic [GRP_W-1:0]  grp;
    logic [ROI_W-1:0]  roi_q;
    logic              row_we;
    logic              accept;
    logic              trig_have;
    trig_info_t        trig_in;
    trig_info_t        trig_q;
    row_t              row_data;
    lane_t             len_word;

    assign trig_in  = '{evt: trig_evt_i, ext_id: trig_ext_i, int_id: trig_int_i};
    assign len_word = packet_len(int'(roi_q), N_GROUPS);

    evw_seq #(.ADDR_W(ADDR_W), .ROI_W(ROI_W), .N_GROUPS(N_GROUPS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .base_i      (base_i),
        .roi_i       (roi_i),
        .samp_valid_i(samp_valid_i),
        .trig_have_i (trig_have),
        .state_o     (seq_state),
        .kind_o      (kind),
        .addr_o      (row_addr),
        .grp_o       (grp),
        .roi_o       (roi_q),
        .we_o        (row_we),
        .accept_o    (accept)
    );

    evw_trig_latch u_trig (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .en_i   (seq_state != ST_IDLE),
        .valid_i(trig_valid_i),
        .info_i (trig_in),
        .have_o (trig_have),
        .info_o (trig_q)
    );

    evw_fmt #(.ROI_W(ROI_W), .GRP_W(GRP_W)) u_fmt (
        .kind_i   (kind),
        .grp_i    (grp),
        .roi_i    (roi_q),
        .len_i    (len_word),
        .version_i(version_i),
        .crate_i  (crate_id_i),
        .board_i  (board_id_i),
        .temp_i   (temp_i),
        .dac_lo_i (dac_i[63:0]),
        .dac_hi_i (dac_i[127:64]),
        .stop_i   (stop_pos_i),
        .samp_i   (samp_data_i),
        .trig_i   (trig_q),
        .row_o    (row_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            wr_en_o   <= row_we;
            wr_addr_o <= row_addr;
            wr_data_o <= row_data;
            done_o    <= (kind == ROW_FOOT);
        end
    end

endmodule

// File: rtl/event_record_writer_chk.sv
module event_record_writer_chk
    import evw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input wr_state_t         seq_state,
    input logic              trig_have,
    input logic              samp_valid_i,
    input logic [63:0]       samp_data_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [63:0]       wr_data_o,
    input logic              done_o
);

    // R1: an idle cycle produces no write on the following cycle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_IDLE) |=> !wr_en_o);

    // R5: a strobed sample in the window appears unchanged on the write port
    assert_sample_write_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_SAMP && samp_valid_i) |=> (wr_en_o && wr_data_o == $past(samp_data_i)));

    // R5: back-to-back sample rows land on consecutive addresses
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_SAMP && samp_valid_i && $past(seq_state == ST_SAMP && samp_valid_i))
        |=> ((wr_addr_o - $past(wr_addr_o)) == ADDR_W'(1)));

    // R7: no write while the trigger identification is still missing
    assert_wait_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_TWAIT && !trig_have) |=> !wr_en_o);

    // R8: done marks the footer write
    assert_done_footer_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (wr_en_o && wr_data_o[15:0] == CRC_FILL && wr_data_o[31:16] == END_FLAG
                    && wr_data_o[63:32] == 32'h0));

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind event_record_writer event_record_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .seq_state   (seq_state),
    .trig_have   (trig_have),
    .samp_valid_i(samp_valid_i),
    .samp_data_i (samp_data_i),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .done_o      (done_o)
);

// File: tb/event_record_writer_test.sv
module event_record_writer_test;

    localparam int NG = 10;

    typedef struct {
        logic [15:0] a;
        logic [63:0] d;
        bit          last;
        string       req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [15:0]  base_i = '0;
    logic [9:0]   roi_i = '0;
    logic [15:0]  version_i = '0;
    logic [3:0]   crate_id_i = '0;
    logic [3:0]   board_id_i = '0;
    logic [63:0]  temp_i = '0;
    logic [127:0] dac_i = '0;
    logic [63:0]  stop_pos_i = '0;
    logic         samp_valid_i = 1'b0;
    logic [63:0]  samp_data_i = '0;
    logic         trig_valid_i = 1'b0;
    logic [31:0]  trig_evt_i = '0;
    logic [15:0]  trig_ext_i = '0;
    logic [15:0]  trig_int_i = '0;
    logic         wr_en_o;
    logic [15:0]  wr_addr_o;
    logic [63:0]  wr_data_o;
    logic         done_o;

    int   checks = 0;
    int   errors = 0;
    int   dones  = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    event_record_writer uut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .roi_i(roi_i),
        .version_i(version_i), .crate_id_i(crate_id_i), .board_id_i(board_id_i),
        .temp_i(temp_i), .dac_i(dac_i), .stop_pos_i(stop_pos_i),
        .samp_valid_i(samp_valid_i), .samp_data_i(samp_data_i),
        .trig_valid_i(trig_valid_i), .trig_evt_i(trig_evt_i),
        .trig_ext_i(trig_ext_i), .trig_int_i(trig_int_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [63:0] d, input bit last, input string req);
        exp_t e;
        e.a = a; e.d = d; e.last = last; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic logic [63:0] lanes(input logic [15:0] l0, input logic [15:0] l1,
                                          input logic [15:0] l2, input logic [15:0] l3);
        return {l3, l2, l1, l0};
    endfunction

    function automatic logic [63:0] samp_word(input int g, input int i, input int seed);
        return lanes(16'(i * 3 + seed), 16'(g * 256 + i) ^ 16'hA5A5, 16'(i), 16'(seed * 7 + g));
    endfunction

    // monitor: pop one expected row per write
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) dones++;
            if (wr_en_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected write", {48'h0, wr_addr_o}, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(wr_addr_o == e.a, e.req, "row address", {48'h0, wr_addr_o}, {48'h0, e.a});
                    check(wr_data_o == e.d, e.req, "row data", wr_data_o, e.d);
                    check(done_o == e.last, "R8", "done with row", {63'h0, done_o}, {63'h0, e.last});
                end
            end else if (done_o) begin
                check(1'b0, "R8", "done without write", 64'h1, 64'h0);
            end
        end
    end

    task automatic run_event(input logic [15:0] base, input int roi, input bit late_trig,
                             input bit gaps, input int seed);
        logic [15:0] len;
        logic [15:0] ga;
        logic [31:0] evt;
        logic [15:0] ext, intid;
        // event inputs
        version_i  = 16'h1000 + 16'(seed);
        crate_id_i = 4'(seed + 2);
        board_id_i = 4'(~seed);
        for (int c = 0; c < 4; c++) begin
            temp_i[16*c +: 16]     = 16'h0100 * 16'(seed) + 16'(c);
            stop_pos_i[16*c +: 16] = 16'(seed * 100 + c * 17);
        end
        for (int k = 0; k < 8; k++) dac_i[16*k +: 16] = 16'hD000 + 16'(seed * 16 + k);
        evt   = 32'h00010000 * 32'(seed) + 32'h1234;
        ext   = 16'hE000 + 16'(seed);
        intid = 16'h1000 + 16'(seed * 3);

        // expected rows, in write order
        len = 16'(24 + 4 * NG * (roi + 3));
        push(base, lanes(16'hFB01, len, version_i, 16'h0), 1'b0, "R2");
        push(base + 16'd3, lanes({4'h0, crate_id_i, 4'h8, board_id_i}, 16'h0, 16'h0, 16'h0), 1'b0, "R3");
        push(base + 16'd4, temp_i, 1'b0, "R3");
        push(base + 16'd5, dac_i[63:0], 1'b0, "R3");
        push(base + 16'd6, dac_i[127:64], 1'b0, "R3");
        for (int g = 0; g < NG; g++) begin
            ga = base + 16'(7 + g * (roi + 3));
            push(ga, lanes(16'(g), 16'h10 | 16'(g), 16'h20 | 16'(g), 16'h30 | 16'(g)), 1'b0, "R4");
            push(ga + 16'd1, stop_pos_i, 1'b0, "R4");
            push(ga + 16'd2, lanes(16'(roi), 16'(roi), 16'(roi), 16'(roi)), 1'b0, "R4");
            for (int i = 0; i < roi; i++) push(ga + 16'd3 + 16'(i), samp_word(g, i, seed), 1'b0, "R5");
        end
        push(base + 16'd1, lanes(evt[15:0], evt[31:16], ext, 16'h0), 1'b0, "R7");
        push(base + 16'd2, lanes(evt[15:0], evt[31:16], intid, 16'h0), 1'b0, "R7");
        push(base + 16'(7 + NG * (roi + 3)), lanes(16'h4242, 16'h04FE, 16'h0, 16'h0), 1'b1, "R8");

        // start, then a stray start and stray samples during the header (R1, R5)
        @(negedge clk);
        base_i = base; roi_i = 10'(roi); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; samp_valid_i = 1'b1; samp_data_i = 64'hDEAD_BEEF_0000_0001;
        @(negedge clk);
        start_i = 1'b1; base_i = 16'h7777; roi_i = 10'd2;
        @(negedge clk);
        start_i = 1'b0;
        if (!late_trig) begin
            trig_valid_i = 1'b1; trig_evt_i = evt; trig_ext_i = ext; trig_int_i = intid;
        end
        @(negedge clk);
        trig_valid_i = 1'b0; samp_valid_i = 1'b0;
        trig_evt_i = 32'hBAD0BAD0; trig_ext_i = 16'hBAD1; trig_int_i = 16'hBAD2;

        if (roi > 0) begin
            for (int g = 0; g < NG; g++) begin
                ga = base + 16'(7 + g * (roi + 3)) + 16'd2;
                do @(negedge clk); while (!(wr_en_o && wr_addr_o == ga));
                for (int i = 0; i < roi; i++) begin
                    if (gaps && (i % 2 == 1)) begin
                        samp_valid_i = 1'b0;
                        samp_data_i  = 64'hFFFF_0000_FFFF_0000;
                        @(negedge clk);
                    end
                    samp_valid_i = 1'b1;
                    samp_data_i  = samp_word(g, i, seed);
                    @(negedge clk);
                end
                // stray strobe after the window; second trigger pulse (R5, R6)
                samp_valid_i = 1'b1;
                samp_data_i  = 64'hCAFE_CAFE_CAFE_CAFE;
                if (!late_trig && g == 0) trig_valid_i = 1'b1;
                @(negedge clk);
                samp_valid_i = 1'b0;
                trig_valid_i = 1'b0;
            end
        end else begin
            ga = base + 16'(7 + (NG - 1) * 3) + 16'd2;
            do @(negedge clk); while (!(wr_en_o && wr_addr_o == ga));
            @(negedge clk);
        end

        if (late_trig) begin
            for (int w = 0; w < 20; w++) begin
                check(wr_en_o == 1'b0, "R7", "write while trigger missing", {63'h0, wr_en_o}, 64'h0);
                @(negedge clk);
            end
            trig_valid_i = 1'b1; trig_evt_i = evt; trig_ext_i = ext; trig_int_i = intid;
            @(negedge clk);
            trig_valid_i = 1'b0;
            trig_evt_i = 32'hBAD0BAD0; trig_ext_i = 16'hBAD1; trig_int_i = 16'hBAD2;
        end

        for (int w = 0; w < 100 && !done_o; w++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wr_en_o == 1'b0, "R1", "wr_en after reset", {63'h0, wr_en_o}, 64'h0);
        check(done_o == 1'b0, "R1", "done after reset", {63'h0, done_o}, 64'h0);

        run_event(16'h2000, 5, 1'b0, 1'b0, 1);
        run_event(16'h0100, 0, 1'b1, 1'b0, 2);
        run_event(16'h4000, 3, 1'b1, 1'b1, 3);
        run_event(16'h2000, 100, 1'b0, 1'b0, 4);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8", "rows left unwritten", 64'(exp_q.size()), 64'h0);
        check(dones == 4, "R8", "done pulse count", 64'(dones), 64'd4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule